// File: doc/BRIEF.md
# Edge-Triggered Event Match Counter

This block counts transitions of an external, asynchronous event signal rather than cycles of its own clock. The event input is brought into the clock domain and filtered. Then, on the polarity chosen by software, it advances a 16-bit counter. When the advanced value reaches a programmable match value, the counter returns to zero and a one-cycle interrupt request is raised. Counting continues on later events after that.

Software drives the block through a small write port with three targets: a mode register, a control register and a match register. The mode register holds the operating-mode field and the polarity bit. The control register holds the run bit and an overflow-enable bit. While the block runs, its configuration is frozen. The match value can be changed at any time. The counter value and the stored configuration can be read back on dedicated outputs.

Top module: `evt_match_counter`

## Requirements
- R1: After reset, count_o is 0000h, irq_o is low and cfg_o is 0.
- R2: The counter advances only while the run bit (control bit 0) is 1 and the mode field (mode register bits 2:0) holds binary 010. Otherwise each accepted event leaves count_o unchanged.
- R3: When the polarity bit (mode register bit 3) is 0, a low-to-high event transition advances the counter. When it is 1, a high-to-low transition advances it.
- R4: When the incremented count equals the match register, count_o becomes 0000h and irq_o is high for exactly one clock in that same cycle. Later events continue counting from zero.
- R5: Writing the run bit to 0 stops counting and sets count_o to 0000h.
- R6: While the run bit is 1, writes to the mode register and to the overflow-enable bit (control bit 1) have no effect. cfg_o reads {overflow-enable, polarity, mode}, bit 4 down to bit 0.
- R7: An event level that lasts only one clock is rejected. A level that lasts two clocks or more is accepted as a transition.
- R8: The match register (write address 2) can be written at any time, including while running. The new value is used from the next comparison.
- R9: Write addresses are 0 for the mode register, 1 for the control register and 2 for the match register. Writes take effect on the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 control, 2 match |
| wr_data | input | 16 | Write data |
| evt_in | input | 1 | Asynchronous event input |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | One-cycle match interrupt request |
| cfg_o | output | 5 | Stored {overflow-enable, polarity, mode} |

## Verification
The main function is driven with trains of full-width pulses under both polarities, with match values that are never reached, reached exactly, and passed several times. This separates a missing clear from a missing interrupt, and a wrong-edge count from an off-by-one compare. Single-clock pulses sit beside two-clock pulses, which shows where the filter threshold lies. A half pulse, held high only, shows which edge is counted after a locked polarity write. A match value lowered mid-run shows that the compare uses the new value at once.

// File: rtl/evt_match_counter.sv
module evt_match_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         evt_in,
  output logic [W-1:0] count_o,
  output logic         irq_o,
  output logic [4:0]   cfg_o
);
  localparam logic [2:0] EVT_MODE = 3'b010;

  logic [2:0]   mode_q;
  logic         pol_q, ovf_q, run_q;
  logic [W-1:0] match_q, cnt_q;
  logic         s1, s2, s3, lvl_q;

  wire wr_mode  = wr_en && wr_addr == 2'd0;
  wire wr_ctrl  = wr_en && wr_addr == 2'd1;
  wire wr_match = wr_en && wr_addr == 2'd2;

  wire          accept = (s2 == s3) && (s2 != lvl_q);
  wire          ev_hit = accept && (s2 == ~pol_q);
  wire          active = run_q && mode_q == EVT_MODE;
  wire [W-1:0]  nxt    = cnt_q + 1'b1;
  wire          hit    = nxt == match_q;
  wire          stop   = wr_ctrl && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; lvl_q <= 1'b0;
    end else begin
      s1 <= evt_in; s2 <= s1; s3 <= s2;
      if (accept) lvl_q <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0; pol_q <= 1'b0; ovf_q <= 1'b0; run_q <= 1'b0; match_q <= '0;
    end else begin
      if (wr_mode && !run_q) begin
        mode_q <= wr_data[2:0];
        pol_q  <= wr_data[3];
      end
      if (wr_ctrl) begin
        run_q <= wr_data[0];
        if (!run_q) ovf_q <= wr_data[1];
      end
      if (wr_match) match_q <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0; irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (stop) cnt_q <= '0;
      else if (active && ev_hit) begin
        cnt_q <= hit ? '0 : nxt;
        irq_o <= hit;
      end
    end

  assign count_o = cnt_q;
  assign cfg_o   = {ovf_q, pol_q, mode_q};
endmodule

module evt_match_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         irq_o,
  input logic [W-1:0] count_o,
  input logic [4:0]   cfg_o
);
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  p_irq_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> count_o == '0);
  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> count_o == '0);
  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(cfg_o));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_o) |-> (count_o == $past(count_o) + 1'b1 || count_o == '0));
endmodule

bind evt_match_counter evt_match_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .irq_o(irq_o),
  .count_o(count_o), .cfg_o(cfg_o)
);

// File: tb/tb_evt_match_counter.sv
module tb_evt_match_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        evt_in = 1'b0;
  logic [15:0] count_o;
  logic        irq_o;
  logic [4:0]  cfg_o;

  int errors = 0, checks = 0, irq_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_match_counter dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt_in(evt_in), .count_o(count_o), .irq_o(irq_o), .cfg_o(cfg_o));

  always @(negedge clk) if (irq_o) irq_seen++;

  // {polarity, match, pulses, expected count, expected irqs}
  localparam int NV = 6;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 16'd5,     8'd3,  16'd3, 8'd0},
    {1'b0, 16'd5,     8'd5,  16'd0, 8'd1},
    {1'b0, 16'd4,     8'd11, 16'd3, 8'd2},
    {1'b1, 16'd3,     8'd7,  16'd1, 8'd2},
    {1'b1, 16'd1,     8'd4,  16'd0, 8'd4},
    {1'b0, 16'hFFFF,  8'd9,  16'd9, 8'd0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk); evt_in = 1'b1;
    repeat (hi) @(negedge clk);
    evt_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic setup(logic pol, logic [15:0] m);
    wr(2'd1, 16'h0000);
    wr(2'd0, {12'd0, pol, 3'b010});
    wr(2'd2, m);
    wr(2'd1, 16'h0001);
    irq_seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", count_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 cfg", cfg_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][48], VEC[i][47:32]);
      for (int p = 0; p < int'(VEC[i][31:24]); p++) pulse(3, 3);
      repeat (6) @(negedge clk);
      chk($sformatf("R3/R4 vec%0d count", i), count_o, int'(VEC[i][23:8]));
      chk($sformatf("R4 vec%0d irqs", i), irq_seen, int'(VEC[i][7:0]));
    end

    // R5: stop clears
    wr(2'd1, 16'h0000);
    chk("R5 stop clears", count_o, 0);
    pulse(3, 3); repeat (6) @(negedge clk);
    chk("R5 stopped no count", count_o, 0);

    // R2: wrong mode does not count
    wr(2'd0, 16'h0003); wr(2'd2, 16'hFFFF); wr(2'd1, 16'h0001);
    pulse(3, 3); pulse(3, 3); repeat (6) @(negedge clk);
    chk("R2 wrong mode", count_o, 0);

    // R7: one-clock pulse rejected, two-clock pulse accepted
    setup(1'b0, 16'hFFFF);
    pulse(1, 4); pulse(1, 4); repeat (6) @(negedge clk);
    chk("R7 narrow rejected", count_o, 0);
    pulse(2, 4); repeat (6) @(negedge clk);
    chk("R7 two-clock accepted", count_o, 1);

    // R6: locked config while running
    setup(1'b0, 16'hFFFF);
    wr(2'd0, 16'h000A);
    wr(2'd1, 16'h0003);
    chk("R6 cfg locked", cfg_o, 5'b00010);
    @(negedge clk); evt_in = 1'b1; repeat (6) @(negedge clk);
    chk("R6 polarity kept rising", count_o, 1);
    evt_in = 1'b0; repeat (6) @(negedge clk);
    chk("R6 falling not counted", count_o, 1);

    // R8: match changed mid-run
    setup(1'b0, 16'd100);
    pulse(3, 3); pulse(3, 3); repeat (4) @(negedge clk);
    wr(2'd2, 16'd3);
    pulse(3, 3); repeat (6) @(negedge clk);
    chk("R8 new match count", count_o, 0);
    chk("R8 new match irq", irq_seen, 1);
    pulse(3, 3); repeat (6) @(negedge clk);
    chk("R4 continues after clear", count_o, 1);

    // R9: stop then config write accepted
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h000A);
    wr(2'd1, 16'h0002);
    chk("R9 cfg written when stopped", cfg_o, 5'b11010);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule